// File: doc/BRIEF.md
# DMA Channel Address and Count Generator

This block holds the per-channel transfer state of an eight-channel DMA engine with a 24-bit address space, and produces one bus address per transfer. Each channel keeps a 16-bit current address with a base copy, a 16-bit current count with a base copy, a page value for the upper address bits, and a small mode word. A controller elsewhere picks the channel to serve and pulses a transfer request for it. The block then presents the 24-bit address for one cycle, steps the channel's address and count, and signals terminal count when the last transfer of the block has been issued.

Channels 0 to 3 move bytes: the page supplies bits 23:16 and the counter supplies bits 15:0. Channels 5 to 7 move 16-bit words: the counter is shifted up one place so that bit 0 is always zero, and the top seven page bits supply bits 23:17. Channel 4 links the two channel groups in cascade. It has no registers and never transfers. The page is never carried into or borrowed from. When a channel reaches terminal count, it either reloads its current address and count from the base copies (autoinitialize) or masks itself.

A small sequencer paces each transfer through three states. IDLE waits for a request. It moves to DRIVE when a request names an unmasked channel other than 4, and stays in IDLE otherwise. DRIVE presents the address for one cycle and always moves to UPDATE. UPDATE steps the channel's registers, raises the terminal-count pulse if the count is zero, and always returns to IDLE.

Top module: `dma_addr_gen`

## Requirements
- R1: On byte channels 0 to 3, `bus_addr` in the DRIVE cycle equals {page[7:0], current address[15:0]}.
- R2: On word channels 5 to 7, `bus_addr` in the DRIVE cycle equals {page[7:1], current address[15:0], 1'b0}. Bit 0 is always zero and page bit 0 is not stored.
- R3: Each transfer adds one to the current address, or subtracts one when mode bit 1 (decrement) is set. The 16-bit value wraps, and the page is unchanged by a carry or a borrow.
- R4: Each transfer decrements the current count. If the count was zero, `tc_pulse` is high during the UPDATE cycle and the count wraps to FFFFh, so a count of N gives N+1 transfers.
- R5: At terminal count with mode bit 0 (autoinitialize) set, the current address and count reload from their base copies, and the mask bit stays clear.
- R6: At terminal count with autoinitialize clear, the channel's `mask` bit is set. While its mask bit is set, requests to that channel are ignored.
- R7: A channel's `tc_status` bit is set at every terminal count and is cleared by a write to that channel's count field.
- R8: Writes use `wr_field` 0 for address, 1 for count, 2 for page (data bits 7:0), and 3 for mode (bit 0 autoinitialize, bit 1 decrement, bit 2 mask). An address or count write loads both the base and the current copy.
- R9: Requests to channel 4 never transfer, and writes to channel 4 have no effect: `mask[4]` reads 1 and `tc_status[4]` reads 0.
- R10: A request is accepted only in IDLE. `addr_valid` is high for exactly one cycle, in the cycle after acceptance, and UPDATE follows it. Requests made during DRIVE or UPDATE are dropped.
- R11: After reset, all mask bits are 1, `tc_status` is 0, `addr_valid` and `tc_pulse` are 0, and `bus_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_chan | input | 3 | Channel targeted by the write |
| wr_field | input | 2 | Field select: 0 address, 1 count, 2 page, 3 mode |
| wr_data | input | 16 | Write data |
| req | input | 1 | Transfer request strobe |
| req_chan | input | 3 | Channel to serve |
| addr_valid | output | 1 | High in the DRIVE cycle |
| bus_addr | output | 24 | Transfer address, zero outside DRIVE |
| tc_pulse | output | 1 | Terminal count, high in the UPDATE cycle |
| mask | output | 8 | Per-channel mask bits |
| tc_status | output | 8 | Per-channel terminal-count flags |

## Verification
The embedded properties check, on every cycle, the rules that hold locally:
- the sequence from DRIVE to UPDATE;
- that channel 4 is never served;
- that bit 0 of a word address is zero;
- that a page does not change while its channel steps;
- the count decrement;
- the reload or mask behaviour at terminal count;
- that a terminal-count pulse follows an address cycle.

Only the bench scenarios can show the rest, by comparing a behavioural model against the outputs on every clock:
- the exact address sequences across 16-bit wraps in both directions;
- N+1 transfers for a count of N;
- that requests to masked channels and requests during a busy cycle are dropped;
- that status is cleared by a count write.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_DRIVE  = 2'd1,
        S_UPDATE = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        FLD_ADDR  = 2'd0,
        FLD_COUNT = 2'd1,
        FLD_PAGE  = 2'd2,
        FLD_MODE  = 2'd3
    } fld_e;

    localparam int MODE_AUTO_BIT = 0;
    localparam int MODE_DEC_BIT  = 1;
    localparam int MODE_MASK_BIT = 2;

endpackage

// File: rtl/dma_ag_chan.sv
module dma_ag_chan
    import dma_ag_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int PAGE_W  = 8,
    parameter int CNT_W   = 16,
    parameter int DATA_W  = 16,
    parameter bit IS_WORD = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [1:0]               wr_field,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     step,
    output logic [ADDR_W+PAGE_W-1:0] bus_addr,
    output logic                     at_tc,
    output logic                     mask,
    output logic                     tc_flag
);

    localparam int PG_KEEP = IS_WORD ? PAGE_W - 1 : PAGE_W;

    logic [ADDR_W-1:0]  addr_q;
    logic [ADDR_W-1:0]  base_addr_q;
    logic [ADDR_W-1:0]  addr_nxt;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   base_cnt_q;
    logic [PG_KEEP-1:0] page_q;
    logic               auto_q;
    logic               dec_q;
    logic               mask_q;
    logic               tcf_q;
    fld_e               fld;

    assign fld      = fld_e'(wr_field);
    assign at_tc    = (cnt_q == '0);
    assign addr_nxt = dec_q ? addr_q - ADDR_W'(1) : addr_q + ADDR_W'(1);
    assign mask     = mask_q;
    assign tc_flag  = tcf_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q      <= '0;
            base_addr_q <= '0;
            cnt_q       <= '0;
            base_cnt_q  <= '0;
            page_q      <= '0;
            auto_q      <= 1'b0;
            dec_q       <= 1'b0;
            mask_q      <= 1'b1;
            tcf_q       <= 1'b0;
        end else if (wr_en) begin
            unique case (fld)
                FLD_ADDR: begin
                    addr_q      <= wr_data[ADDR_W-1:0];
                    base_addr_q <= wr_data[ADDR_W-1:0];
                end
                FLD_COUNT: begin
                    cnt_q      <= wr_data[CNT_W-1:0];
                    base_cnt_q <= wr_data[CNT_W-1:0];
                    tcf_q      <= 1'b0;
                end
                FLD_PAGE: page_q <= wr_data[PAGE_W-1 -: PG_KEEP];
                FLD_MODE: begin
                    auto_q <= wr_data[MODE_AUTO_BIT];
                    dec_q  <= wr_data[MODE_DEC_BIT];
                    mask_q <= wr_data[MODE_MASK_BIT];
                end
            endcase
        end else if (step) begin
            if (at_tc) begin
                tcf_q <= 1'b1;
                if (auto_q) begin
                    addr_q <= base_addr_q;
                    cnt_q  <= base_cnt_q;
                end else begin
                    addr_q <= addr_nxt;
                    cnt_q  <= cnt_q - CNT_W'(1);
                    mask_q <= 1'b1;
                end
            end else begin
                addr_q <= addr_nxt;
                cnt_q  <= cnt_q - CNT_W'(1);
            end
        end
    end

    generate
        if (IS_WORD) begin : g_word
            assign bus_addr = {page_q, addr_q, 1'b0};
        end else begin : g_byte
            assign bus_addr = {page_q, addr_q};
        end
    endgenerate

    // R3
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_en) |=> $stable(page_q));

    // R4
    count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_en && !at_tc) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_en && at_tc && auto_q) |=>
            ((addr_q == base_addr_q) && (cnt_q == base_cnt_q) && !mask_q));

    // R6
    mask_on_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_en && at_tc && !auto_q) |=> (mask_q && tcf_q));

endmodule

// File: rtl/dma_ag_fsm.sv
module dma_ag_fsm
    import dma_ag_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int CASCADE_CH = 4,
    parameter int CH_W       = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [CH_W-1:0]   req_chan,
    input  logic [NUM_CH-1:0] chan_mask,
    output logic              addr_valid,
    output logic              in_update,
    output logic [CH_W-1:0]   act_chan
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       accept;

    assign accept = req && (req_chan != CH_W'(CASCADE_CH)) && !chan_mask[req_chan];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept) state_d = S_DRIVE;
            S_DRIVE:  state_d = S_UPDATE;
            S_UPDATE: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            act_chan <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && accept) act_chan <= req_chan;
        end
    end

    always_comb begin
        addr_valid = 1'b0;
        in_update  = 1'b0;
        unique case (state_q)
            S_IDLE:   ;
            S_DRIVE:  addr_valid = 1'b1;
            S_UPDATE: in_update  = 1'b1;
            default:  ;
        endcase
    end

    // R10
    drive_then_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> (in_update && $stable(act_chan)));

    // R9
    no_cascade_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> (act_chan != CH_W'(CASCADE_CH)));

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_ag_pkg::*;
#(
    parameter  int NUM_CH        = 8,
    parameter  int CASCADE_CH    = 4,
    parameter  int FIRST_WORD_CH = 5,
    parameter  int ADDR_W        = 16,
    parameter  int PAGE_W        = 8,
    parameter  int CNT_W         = 16,
    localparam int CH_W          = $clog2(NUM_CH),
    localparam int BUS_W         = ADDR_W + PAGE_W,
    localparam int DATA_W        = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic [1:0]        wr_field,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              req,
    input  logic [CH_W-1:0]   req_chan,
    output logic              addr_valid,
    output logic [BUS_W-1:0]  bus_addr,
    output logic              tc_pulse,
    output logic [NUM_CH-1:0] mask,
    output logic [NUM_CH-1:0] tc_status
);

    logic [BUS_W-1:0]  addr_v [NUM_CH];
    logic [NUM_CH-1:0] at_tc_v;
    logic              in_update;
    logic [CH_W-1:0]   act_chan;

    dma_ag_fsm #(
        .NUM_CH     (NUM_CH),
        .CASCADE_CH (CASCADE_CH),
        .CH_W       (CH_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .req_chan   (req_chan),
        .chan_mask  (mask),
        .addr_valid (addr_valid),
        .in_update  (in_update),
        .act_chan   (act_chan)
    );

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            if (i == CASCADE_CH) begin : g_cascade
                assign addr_v[i]    = '0;
                assign at_tc_v[i]   = 1'b0;
                assign mask[i]      = 1'b1;
                assign tc_status[i] = 1'b0;
            end else begin : g_live
                dma_ag_chan #(
                    .ADDR_W  (ADDR_W),
                    .PAGE_W  (PAGE_W),
                    .CNT_W   (CNT_W),
                    .DATA_W  (DATA_W),
                    .IS_WORD (i >= FIRST_WORD_CH)
                ) u_chan (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .wr_en    (wr_en && (wr_chan == CH_W'(i))),
                    .wr_field (wr_field),
                    .wr_data  (wr_data),
                    .step     (in_update && (act_chan == CH_W'(i))),
                    .bus_addr (addr_v[i]),
                    .at_tc    (at_tc_v[i]),
                    .mask     (mask[i]),
                    .tc_flag  (tc_status[i])
                );
            end
        end
    endgenerate

    assign bus_addr = addr_valid ? addr_v[act_chan] : '0;
    assign tc_pulse = in_update && at_tc_v[act_chan];

    // R2
    word_a0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && (act_chan >= CH_W'(FIRST_WORD_CH))) |-> (bus_addr[0] == 1'b0));

    // R4
    tc_after_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> $past(addr_valid));

    // R11
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |-> (bus_addr == '0));

endmodule

// File: tb/dma_addr_gen_tb.sv
module dma_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_chan = '0;
    logic [1:0]  wr_field = '0;
    logic [15:0] wr_data = '0;
    logic        req = 1'b0;
    logic [2:0]  req_chan = '0;
    logic        addr_valid;
    logic [23:0] bus_addr;
    logic        tc_pulse;
    logic [7:0]  mask;
    logic [7:0]  tc_status;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit started = 0;

    always #4 clk = ~clk;

    dma_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
        .wr_field(wr_field), .wr_data(wr_data), .req(req), .req_chan(req_chan),
        .addr_valid(addr_valid), .bus_addr(bus_addr), .tc_pulse(tc_pulse),
        .mask(mask), .tc_status(tc_status)
    );

    // behavioural reference model
    logic [15:0] m_addr [8];
    logic [15:0] m_base_addr [8];
    logic [15:0] m_cnt [8];
    logic [15:0] m_base_cnt [8];
    logic [7:0]  m_page [8];
    bit          m_auto [8];
    bit          m_dec [8];
    bit          m_mask [8];
    bit          m_tcs [8];
    int          m_phase = 0;
    int          m_act = 0;

    function automatic logic [23:0] fmt(int ch);
        if (ch >= 5) return {m_page[ch][7:1], m_addr[ch], 1'b0};
        return {m_page[ch], m_addr[ch]};
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            for (int c = 0; c < 8; c++) begin
                m_addr[c] = 0; m_base_addr[c] = 0; m_cnt[c] = 0; m_base_cnt[c] = 0;
                m_page[c] = 0; m_auto[c] = 0; m_dec[c] = 0; m_mask[c] = 1; m_tcs[c] = 0;
            end
            m_phase = 0;
            m_act = 0;
        end else begin
            int nphase;
            nphase = m_phase;
            if (m_phase == 0) begin
                if (req && req_chan != 4 && !m_mask[req_chan]) begin
                    nphase = 1;
                    m_act = req_chan;
                end
            end else if (m_phase == 1) begin
                nphase = 2;
            end else begin
                nphase = 0;
                if (!(wr_en && wr_chan == m_act)) begin
                    bit last;
                    last = (m_cnt[m_act] == 0);
                    if (last && m_auto[m_act]) begin
                        m_addr[m_act] = m_base_addr[m_act];
                        m_cnt[m_act] = m_base_cnt[m_act];
                    end else begin
                        m_addr[m_act] = m_dec[m_act] ? m_addr[m_act] - 16'd1 : m_addr[m_act] + 16'd1;
                        m_cnt[m_act] = m_cnt[m_act] - 16'd1;
                        if (last) m_mask[m_act] = 1;
                    end
                    if (last) m_tcs[m_act] = 1;
                end
            end
            if (wr_en && wr_chan != 4) begin
                case (wr_field)
                    2'd0: begin m_addr[wr_chan] = wr_data; m_base_addr[wr_chan] = wr_data; end
                    2'd1: begin m_cnt[wr_chan] = wr_data; m_base_cnt[wr_chan] = wr_data; m_tcs[wr_chan] = 0; end
                    2'd2: m_page[wr_chan] = wr_data[7:0];
                    default: begin
                        m_auto[wr_chan] = wr_data[0];
                        m_dec[wr_chan] = wr_data[1];
                        m_mask[wr_chan] = wr_data[2];
                    end
                endcase
            end
            m_phase = nphase;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (started) begin
            logic [23:0] eaddr;
            logic [7:0] emask;
            logic [7:0] etcs;
            bit etc;
            eaddr = (m_phase == 1) ? fmt(m_act) : 24'h0;
            etc = (m_phase == 2) && (m_cnt[m_act] == 0);
            for (int c = 0; c < 8; c++) begin
                emask[c] = m_mask[c];
                etcs[c] = m_tcs[c];
            end
            chk(addr_valid === (m_phase == 1), "R10 addr_valid", 32'(addr_valid), 32'(m_phase == 1));
            chk(bus_addr === eaddr, (m_act >= 5) ? "R2 bus_addr" : "R1 bus_addr", 32'(bus_addr), 32'(eaddr));
            chk(tc_pulse === etc, "R4 tc_pulse", 32'(tc_pulse), 32'(etc));
            chk(mask === emask, "R6 mask", 32'(mask), 32'(emask));
            chk(tc_status === etcs, "R7 tc_status", 32'(tc_status), 32'(etcs));
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog actual=%0d expected<20000", cyc);
            finish_run();
        end
    end

    task automatic wr(input int ch, input int fld, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_chan = ch[2:0]; wr_field = fld[1:0]; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic xfer(input int ch, input logic [23:0] ea, input bit etc, input string tag);
        @(negedge clk);
        req = 1; req_chan = ch[2:0];
        @(negedge clk);
        req = 0;
        chk(addr_valid === 1'b1, {tag, " valid"}, 32'(addr_valid), 32'd1);
        chk(bus_addr === ea, {tag, " addr"}, 32'(bus_addr), 32'(ea));
        @(negedge clk);
        chk(tc_pulse === etc, {tag, " tc"}, 32'(tc_pulse), 32'(etc));
        @(negedge clk);
    endtask

    task automatic xfer_none(input int ch, input string tag);
        int seen;
        seen = 0;
        @(negedge clk);
        req = 1; req_chan = ch[2:0];
        @(negedge clk);
        req = 0;
        for (int k = 0; k < 3; k++) begin
            if (addr_valid) seen++;
            @(negedge clk);
        end
        chk(seen == 0, tag, 32'(seen), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(mask === 8'hFF, "R11 mask reset", 32'(mask), 32'hFF);
        chk(tc_status === 8'h00, "R11 status reset", 32'(tc_status), 32'h0);
        chk(addr_valid === 1'b0 && bus_addr === 24'h0, "R11 bus idle", 32'(bus_addr), 32'h0);
        rst_n = 1;

        // R1 byte channel, count 2 gives three transfers
        wr(0, 2, 16'h0056);
        wr(0, 0, 16'h1234);
        wr(0, 1, 16'h0002);
        wr(0, 3, 16'h0000);
        xfer(0, 24'h561234, 0, "R1 ch0 first");
        xfer(0, 24'h561235, 0, "R1 ch0 second");
        xfer(0, 24'h561236, 1, "R4 ch0 last");
        chk(mask[0] === 1'b1, "R6 ch0 masked", 32'(mask[0]), 32'd1);
        chk(tc_status[0] === 1'b1, "R7 ch0 status", 32'(tc_status[0]), 32'd1);
        xfer_none(0, "R6 masked ch0 ignored");

        // R2 / R3 word channel, increment across 16-bit wrap
        wr(5, 2, 16'h0013);
        wr(5, 0, 16'hFFFF);
        wr(5, 1, 16'h0001);
        wr(5, 3, 16'h0000);
        xfer(5, 24'h13FFFE, 0, "R2 ch5 first");
        xfer(5, 24'h120000, 1, "R3 ch5 wrap keeps page");

        // R3 word channel, decrement across borrow
        wr(6, 2, 16'h0022);
        wr(6, 0, 16'h0000);
        wr(6, 1, 16'h0003);
        wr(6, 3, 16'h0002);
        xfer(6, 24'h220000, 0, "R3 ch6 first");
        xfer(6, 24'h23FFFE, 0, "R3 ch6 borrow keeps page");

        // R5 autoinitialize with decrement
        wr(2, 2, 16'h00A0);
        wr(2, 0, 16'h0001);
        wr(2, 1, 16'h0001);
        wr(2, 3, 16'h0003);
        xfer(2, 24'hA00001, 0, "R5 ch2 first");
        xfer(2, 24'hA00000, 1, "R5 ch2 last");
        chk(mask[2] === 1'b0, "R5 ch2 stays unmasked", 32'(mask[2]), 32'd0);
        xfer(2, 24'hA00001, 0, "R5 ch2 reloaded");

        // R9 cascade channel and masked channel
        wr(4, 3, 16'h0000);
        chk(mask[4] === 1'b1, "R9 ch4 mask stuck", 32'(mask[4]), 32'd1);
        xfer_none(4, "R9 ch4 ignored");
        xfer_none(3, "R6 reset-masked ch3 ignored");

        // R10 request held across busy cycles gives one transfer
        begin
            int pulses;
            pulses = 0;
            @(negedge clk);
            req = 1; req_chan = 3'd2;
            @(negedge clk);
            if (addr_valid) pulses++;
            @(negedge clk);
            req = 0;
            if (addr_valid) pulses++;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                if (addr_valid) pulses++;
            end
            chk(pulses == 1, "R10 busy request dropped", 32'(pulses), 32'd1);
        end

        // R7 clear by count write; R8 address write loads current
        wr(0, 1, 16'h0000);
        chk(tc_status[0] === 1'b0, "R7 status cleared", 32'(tc_status[0]), 32'd0);
        wr(0, 0, 16'h4000);
        wr(0, 3, 16'h0000);
        xfer(0, 24'h564000, 1, "R8 ch0 new address");
        chk(mask[0] === 1'b1, "R6 ch0 masked again", 32'(mask[0]), 32'd1);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule